// File: doc/BRIEF.md
# Power-down and reset sequencer

This block controls the oscillator enable, the core clock gate and the two reset outputs of a small microcontroller core. While the core runs, it watches for a power-down request. It acts on the request only on the cycle in which an instruction retires, so the instruction that asked for power-down is the last one to finish. It then drops the oscillator enable and the core clock enable. Both stay low until the hardware reset pin is driven.

A hardware reset is the only way out of power-down. The reset asserts a register-file clear for the special-function registers and a separate core hold. No output of the block ever touches the data RAM, so RAM contents survive both power-down and reset. Release is staged. First the block waits for the oscillator-good input. It then counts a parameterised number of reference-clock cycles of stable oscillation. After that it drops the register clear, and one cycle later the core hold.

The block runs on an always-on reference clock `clk`. The reset pin `hw_rst_n` is active low and is sampled synchronously on each rising edge.

Top module: `pwrdn_rst_seq`

## Requirements
- R1: On the rising edge after `hw_rst_n` is sampled low, the outputs become `osc_run`=1, `core_clk_on`=0, `sfr_clear`=1, `core_hold`=1. They stay at these values while `hw_rst_n` remains low.
- R2: After reset is released, the outputs keep the R1 values for as long as `osc_ok` is sampled low.
- R3: Number the edges from the first one that samples `osc_ok` high in the waiting phase; that edge is edge 1. From edge 1, `core_clk_on` is 1. `sfr_clear` falls at edge SETTLE_CYCLES+1. `core_hold` falls at edge SETTLE_CYCLES+2.
- R4: If `osc_ok` is sampled low during the settling count, the block goes back to the R2 values (`core_clk_on`=0). The full count restarts once `osc_ok` is high again.
- R5: While running (outputs 1,1,0,0), an edge that samples both `pd_req` and `retire` high makes all four outputs 0 from that edge on.
- R6: While running, `pd_req` high with `retire` low has no effect, and `retire` high with `pd_req` low has no effect. The outputs stay 1,1,0,0.
- R7: In power-down, `pd_req`, `retire` and `osc_ok` have no effect. All four outputs stay 0, including `sfr_clear` and `core_hold`, so the register state is kept.
- R8: `pd_req` and `retire` are ignored from the start of reset until the core hold has been released.
- R9: `hw_rst_n` low ends power-down with the R1 values on the next edge. The release then follows R2 and R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| hw_rst_n | input | 1 | Hardware reset pin, active low, synchronous |
| pd_req | input | 1 | Power-down request from the core |
| retire | input | 1 | One-cycle pulse when an instruction completes |
| osc_ok | input | 1 | Oscillator reports stable oscillation |
| osc_run | output | 1 | Oscillator enable |
| core_clk_on | output | 1 | Core clock gate enable |
| sfr_clear | output | 1 | Special-function register reset |
| core_hold | output | 1 | Core reset (held until start-up count ends) |

## Verification
Several rules are checked by assertions on every cycle:
- Power-down is left only through reset (R7).
- A clock-off with the core released must follow a retiring request (R5).
- Power-down never asserts the register clear (R7).
- The settle counter never passes its limit, and the core hold only drops after a completed count with the oscillator good (R3).

The exact release edges, the restart of the count after an oscillator dropout, and the inputs ignored during reset and settling can only be shown by the bench's scenarios. Those scenarios count edges from known stimulus.

// File: rtl/pds_pkg.sv
// Package: shared state encoding and output decode for the power-down sequencer.
// Assumes: one state register drives all four outputs through seq_decode.
package pds_pkg;

    typedef enum logic [2:0] {
        SQ_HOLD   = 3'd0,  // hardware reset pin asserted
        SQ_WAIT   = 3'd1,  // waiting for oscillator good
        SQ_SETTLE = 3'd2,  // counting stable oscillator cycles
        SQ_ARM    = 3'd3,  // SFRs released, core still held
        SQ_RUN    = 3'd4,  // core executing
        SQ_DOWN   = 3'd5   // power-down, oscillator stopped
    } seq_state_e;

    typedef struct packed {
        logic osc_run;
        logic clk_on;
        logic sfr_clear;
        logic core_hold;
    } seq_out_t;

    // Map a state to the four control outputs.
    function automatic seq_out_t seq_decode(seq_state_e s);
        seq_out_t o;
        case (s)
            SQ_HOLD, SQ_WAIT: o = '{osc_run: 1'b1, clk_on: 1'b0, sfr_clear: 1'b1, core_hold: 1'b1};
            SQ_SETTLE:        o = '{osc_run: 1'b1, clk_on: 1'b1, sfr_clear: 1'b1, core_hold: 1'b1};
            SQ_ARM:           o = '{osc_run: 1'b1, clk_on: 1'b1, sfr_clear: 1'b0, core_hold: 1'b1};
            SQ_RUN:           o = '{osc_run: 1'b1, clk_on: 1'b1, sfr_clear: 1'b0, core_hold: 1'b0};
            default:          o = '{osc_run: 1'b0, clk_on: 1'b0, sfr_clear: 1'b0, core_hold: 1'b0};
        endcase
        return o;
    endfunction

endpackage

// File: rtl/pds_settle_timer.sv
// Module: counts stable-oscillator cycles before reset release.
// Assumes: CYCLES >= 2; 'run' is high only while settling with osc good,
// and 'clear' restarts the count from zero.
module pds_settle_timer #(
    parameter int CYCLES = 1024
) (
    input  logic clk,
    input  logic hw_rst_n,
    input  logic run,
    input  logic clear,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    // Advance the settle count while enabled, restart on clear or reset.
    always_ff @(posedge clk) begin
        if (!hw_rst_n || clear) begin
            cnt <= '0;
        end else if (run && cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = run && (cnt == LAST);

    // R3: the count never runs past its terminal value.
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!hw_rst_n)
        cnt <= LAST);

endmodule

// File: rtl/pds_pd_gate.sv
// Module: qualifies a power-down request with an instruction-retire pulse.
// Assumes: 'armed' is high only while the core runs; elsewhere requests are ignored.
module pds_pd_gate (
    input  logic pd_req,
    input  logic retire,
    input  logic armed,
    output logic take
);
    // Accept power-down only at an instruction boundary while running.
    always_comb begin
        take = armed && pd_req && retire;
    end
endmodule

// File: rtl/pds_seq_fsm.sv
// Module: sequencing state machine for reset, settling, run and power-down.
// Assumes: synchronous active-low hardware reset; 'take' and 'settled' come
// from the gate and timer modules.
module pds_seq_fsm
    import pds_pkg::*;
(
    input  logic       clk,
    input  logic       hw_rst_n,
    input  logic       osc_ok,
    input  logic       take,
    input  logic       settled,
    output seq_state_e state
);
    seq_state_e nxt;

    // Choose the next sequencing step.
    always_comb begin
        nxt = state;
        case (state)
            SQ_HOLD:   nxt = SQ_WAIT;
            SQ_WAIT:   if (osc_ok) nxt = SQ_SETTLE;
            SQ_SETTLE: begin
                if (!osc_ok)      nxt = SQ_WAIT;
                else if (settled) nxt = SQ_ARM;
            end
            SQ_ARM:    nxt = SQ_RUN;
            SQ_RUN:    if (take) nxt = SQ_DOWN;
            SQ_DOWN:   nxt = SQ_DOWN;
            default:   nxt = SQ_HOLD;
        endcase
    end

    // Hold the state register; the reset pin overrides everything.
    always_ff @(posedge clk) begin
        if (!hw_rst_n) state <= SQ_HOLD;
        else           state <= nxt;
    end

    // R3: the ARM step is only reached from a completed count with osc good.
    a_r3_arm_after_count: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (state == SQ_ARM) |-> $past(settled && osc_ok));

    // R7: power-down is left only through the reset pin.
    a_r7_down_sticky: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (state == SQ_DOWN) |=> (state == SQ_DOWN));

endmodule

// File: rtl/pwrdn_rst_seq.sv
// Module: top of the power-down and reset sequencer.
// Assumes: clk is an always-on reference; hw_rst_n is the synchronous active-low
// hardware reset; the block never drives any RAM control.
module pwrdn_rst_seq
    import pds_pkg::*;
#(
    parameter int SETTLE_CYCLES = 1024
) (
    input  logic clk,
    input  logic hw_rst_n,
    input  logic pd_req,
    input  logic retire,
    input  logic osc_ok,
    output logic osc_run,
    output logic core_clk_on,
    output logic sfr_clear,
    output logic core_hold
);
    seq_state_e state;
    seq_out_t   outs;
    logic       take;
    logic       settled;
    logic       tmr_run;
    logic       tmr_clear;

    // Timer runs only while settling with a good oscillator.
    always_comb begin
        tmr_run   = (state == SQ_SETTLE) && osc_ok;
        tmr_clear = !tmr_run;
    end

    pds_pd_gate i_gate (
        .pd_req (pd_req),
        .retire (retire),
        .armed  (state == SQ_RUN),
        .take   (take)
    );

    pds_settle_timer #(.CYCLES(SETTLE_CYCLES)) i_timer (
        .clk      (clk),
        .hw_rst_n (hw_rst_n),
        .run      (tmr_run),
        .clear    (tmr_clear),
        .done     (settled)
    );

    pds_seq_fsm i_fsm (
        .clk      (clk),
        .hw_rst_n (hw_rst_n),
        .osc_ok   (osc_ok),
        .take     (take),
        .settled  (settled),
        .state    (state)
    );

    // Drive the outputs from the decoded state.
    always_comb begin
        outs        = seq_decode(state);
        osc_run     = outs.osc_run;
        core_clk_on = outs.clk_on;
        sfr_clear   = outs.sfr_clear;
        core_hold   = outs.core_hold;
    end

    // R5: a clock stop with the core released must follow a retiring request.
    a_r5_stop_on_retire: assert property (@(posedge clk) disable iff (!hw_rst_n)
        ($fell(core_clk_on) && !core_hold) |-> $past(pd_req && retire));

    // R7: once the oscillator is off it stays off until reset.
    a_r7_osc_stays_off: assert property (@(posedge clk) disable iff (!hw_rst_n)
        !osc_run |=> !osc_run);

    // R7: power-down keeps the registers, so no clear while stopped.
    a_r7_no_clear_in_down: assert property (@(posedge clk) disable iff (!hw_rst_n)
        !osc_run |-> (!sfr_clear && !core_hold));

    // R3: the core hold drops only after the register clear has dropped.
    a_r3_hold_after_clear: assert property (@(posedge clk) disable iff (!hw_rst_n)
        $fell(core_hold) |-> $past(!sfr_clear));

endmodule

// File: tb/test_pwrdn_rst_seq.sv
module test_pwrdn_rst_seq;
    localparam int N = 8;

    logic clk = 1'b0;
    logic hw_rst_n = 1'b0, pd_req = 1'b0, retire = 1'b0, osc_ok = 1'b0;
    logic osc_run, core_clk_on, sfr_clear, core_hold;
    int   errors = 0, checks = 0;
    bit   finished = 1'b0;

    always #5 clk = ~clk;

    pwrdn_rst_seq #(.SETTLE_CYCLES(N)) i_pwrdn_rst_seq (
        .clk(clk), .hw_rst_n(hw_rst_n), .pd_req(pd_req), .retire(retire),
        .osc_ok(osc_ok), .osc_run(osc_run), .core_clk_on(core_clk_on),
        .sfr_clear(sfr_clear), .core_hold(core_hold)
    );

    // Output pattern {osc_run, core_clk_on, sfr_clear, core_hold}
    localparam logic [3:0] P_RST = 4'b1011, P_SET = 4'b1111, P_RUN = 4'b1100, P_DOWN = 4'b0000;

    // Run-state vectors: {pd_req, retire, expected pattern}
    localparam logic [5:0] VEC [6] = '{
        {2'b00, 4'b1100}, {2'b10, 4'b1100}, {2'b01, 4'b1100},
        {2'b11, 4'b0000}, {2'b11, 4'b0000}, {2'b01, 4'b0000}
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic logic [3:0] pat();
        return {osc_run, core_clk_on, sfr_clear, core_hold};
    endfunction

    // Called at a negedge in the waiting phase, right after osc_ok is set high.
    task automatic measure(input string tag);
        int k_clr = 0, k_hold = 0;
        for (int k = 1; k <= N + 4; k++) begin
            step();
            if (k == 1) chk({tag, " R3 clock on at edge 1"}, pat(), P_SET);
            if (!sfr_clear && k_clr == 0) k_clr = k;
            if (!core_hold && k_hold == 0) k_hold = k;
        end
        chk({tag, " R3 sfr_clear release edge"}, k_clr, N + 1);
        chk({tag, " R3 core_hold release edge"}, k_hold, N + 2);
        chk({tag, " R3 running pattern"}, pat(), P_RUN);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step(); step();
        chk("R1 reset pattern", pat(), P_RST);
        pd_req = 1'b1; retire = 1'b1;
        step();
        chk("R8 request ignored in reset", pat(), P_RST);
        pd_req = 1'b0; retire = 1'b0;

        hw_rst_n = 1'b1;
        for (int i = 0; i < 5; i++) step();
        chk("R2 waiting for osc_ok", pat(), P_RST);

        osc_ok = 1'b1;
        measure("first");

        // Table walk in the running state.
        for (int i = 0; i < 6; i++) begin
            {pd_req, retire} = VEC[i][5:4];
            step();
            chk($sformatf("R5/R6 vector %0d", i), pat(), VEC[i][3:0]);
        end
        pd_req = 1'b0; retire = 1'b0;

        // R7: inputs have no effect in power-down.
        osc_ok = 1'b0; step();
        chk("R7 osc_ok low in down", pat(), P_DOWN);
        osc_ok = 1'b1; pd_req = 1'b1; step(); step();
        chk("R7 inputs ignored in down", pat(), P_DOWN);
        pd_req = 1'b0;

        // R9: reset leaves power-down.
        hw_rst_n = 1'b0; step();
        chk("R9 reset exits power-down", pat(), P_RST);
        osc_ok = 1'b0; hw_rst_n = 1'b1; step();
        chk("R9 waiting after reset", pat(), P_RST);

        // R4: osc dropout during settling restarts the count.
        osc_ok = 1'b1;
        for (int i = 0; i < 3; i++) step();
        chk("R4 settling before dropout", pat(), P_SET);
        osc_ok = 1'b0; step();
        chk("R4 dropout returns to wait", pat(), P_RST);
        osc_ok = 1'b1;
        measure("restart R4");

        // R8: requests during settling are ignored.
        hw_rst_n = 1'b0; step();
        hw_rst_n = 1'b1; osc_ok = 1'b0; step();
        osc_ok = 1'b1; step();
        pd_req = 1'b1; retire = 1'b1; step(); step();
        chk("R8 request ignored in settle", pat(), P_SET);
        pd_req = 1'b0; retire = 1'b0;
        for (int i = 0; i < N + 2; i++) step();
        chk("R8 core runs after ignored request", pat(), P_RUN);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule